// File: doc/BRIEF.md
# Dual-Host Register Bank

This block is a small register bank on a Wishbone-style bus that two bus hosts share. A registered arbiter hands the bus to one host at a time. Host Q wins when both ask at once, and a host keeps the bus for as long as it holds its cycle line. Each accepted access gets a one-cycle response on that host's own response lines. The other host sees silence.

The bank holds three register classes. Status words are read-only views of values that neighbouring logic supplies. Setting words are read/write, come out of reset with fixed values, and drive configuration outputs. Trigger flags are raised by a bus write and drive a launch level to other logic. That logic lowers them through a dedicated clear input when its job is done. All vectors are numbered with the MSB at the highest index. The "last bit" of a data word is therefore data bit 0, its LSB.

Top module: `regbank_dual_host`

## Requirements
- R1: Host Q (index 0) and host P (index 1) ask for the bus with their cycle lines. When both ask while the bus is free, Q is served first and P receives no response until Q releases its cycle line.
- R2: A granted host keeps the bus while its cycle line stays high, even across several accesses and even if Q asks meanwhile. The bus changes hands only when the owner drops its cycle line.
- R3: A host that does not hold the bus sees ack, err and retry low and read data zero.
- R4: Each accepted access draws exactly one response: either a one-cycle ack or a one-cycle err on the owning host's lines, never both. Retry is never raised.
- R5: Status words sit at addresses 0x0, 0x1 and 0x2. A read returns status field k (stat_in bits [8k+7:8k]) at that moment. A write to these addresses draws err instead of ack and changes nothing.
- R6: Setting words sit at addresses 0x6, 0x7 and 0x8 and leave reset holding 0x05, 0x3C and 0xAA. A write stores the data and a read returns it. Word k drives set_out bits [8k+7:8k].
- R7: Trigger flags sit at addresses 0xA, 0xB and 0xC, one flag per address, on trig_out bits 0, 1 and 2. A write sets the flag only when write data bit 0 is 1. Any other write data leaves the flag unchanged.
- R8: A trigger flag stays high until its trig_clr bit is seen high at a clock edge. If a setting write and a clear land on the same edge, the flag ends high.
- R9: A read of a trigger address returns the flag in data bit 0, with bits 7..1 zero.
- R10: An access to any address outside the three ranges draws err, returns read data zero and changes no state.
- R11: After reset, no responses are pending, the settings hold their reset values and all trigger flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_cyc | input | 2 | Per-host cycle (bus request) line |
| m_stb | input | 2 | Per-host strobe |
| m_we | input | 2 | Per-host write enable |
| m_adr | input | 8 | Per-host address, host i at bits [4i+3:4i] |
| m_wdat | input | 16 | Per-host write data, host i at bits [8i+7:8i] |
| s_ack | output | 2 | Per-host acknowledge |
| s_err | output | 2 | Per-host error |
| s_rty | output | 2 | Per-host retry, always low |
| s_rdat | output | 16 | Per-host read data, host i at bits [8i+7:8i] |
| stat_in | input | 24 | Status fields supplied by other logic |
| set_out | output | 24 | Setting word values |
| trig_out | output | 3 | Trigger launch flags |
| trig_clr | input | 3 | Trigger clear requests from the launched logic |

## Verification
The bench raises both cycle lines on the same edge to check that Q is served first. It then lets P take the bus and has Q ask while P still holds it. A design that re-arbitrated on every access would hand the bus to Q in the middle of P's sequence. Trigger flags are checked against a write with data bit 0 clear, against a bare clear pulse, and against a clear that lands on the same edge as the setting write. A wrong priority there would drop the flag, and a wrong field position would set it from the wrong data bit. Randomised traffic mixes writes to status words and unmapped addresses. This catches decoders that ack those accesses or change a setting on them.

// File: rtl/rb_pkg.sv
package rb_pkg;
  localparam int NUM_HOSTS   = 2;
  localparam int ADDR_W      = 4;
  localparam int DATA_W      = 8;
  localparam int NUM_STAT    = 3;
  localparam int NUM_SET     = 3;
  localparam int NUM_TRIG    = 3;
  localparam int STAT_BASE   = 0;
  localparam int SET_BASE    = 6;
  localparam int TRIG_BASE   = 10;
  localparam int TRIG_BIT    = 0;
  localparam logic [NUM_SET*DATA_W-1:0] SET_RESET_VALS = 24'hAA3C05;
endpackage

// File: rtl/rb_arbiter.sv
module rb_arbiter #(
  parameter int NM = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NM-1:0] cyc,
  output logic [NM-1:0] gnt
);
  logic [NM-1:0] gnt_nxt;
  logic          owner_holds;

  always_comb begin
    owner_holds = |(gnt & cyc);
    gnt_nxt     = '0;
    if (owner_holds) begin
      gnt_nxt = gnt;
    end else begin
      // lowest index wins
      for (int i = NM - 1; i >= 0; i--) begin
        if (cyc[i]) begin
          gnt_nxt    = '0;
          gnt_nxt[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gnt <= '0;
    else     gnt <= gnt_nxt;
  end
endmodule

// File: rtl/rb_regs.sv
module rb_regs #(
  parameter int AW        = 4,
  parameter int DW        = 8,
  parameter int NSTAT     = 3,
  parameter int NSET      = 3,
  parameter int NTRIG     = 3,
  parameter int STAT_BASE = 0,
  parameter int SET_BASE  = 6,
  parameter int TRIG_BASE = 10,
  parameter int TRIG_BIT  = 0,
  parameter logic [NSET*DW-1:0] SET_RST = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               go,
  input  logic               we,
  input  logic [AW-1:0]      adr,
  input  logic [DW-1:0]      wdat,
  input  logic [NSTAT*DW-1:0] stat_in,
  input  logic [NTRIG-1:0]   trig_clr,
  output logic               acc_ok,
  output logic               acc_err,
  output logic [DW-1:0]      rdat,
  output logic [NSET*DW-1:0] set_out,
  output logic [NTRIG-1:0]   trig_out
);
  logic [DW-1:0]    set_q [NSET];
  logic [NSET-1:0]  set_hit;
  logic [NTRIG-1:0] trig_hit;
  logic             mapped;
  logic             read_only;

  always_comb begin
    mapped    = 1'b0;
    read_only = 1'b0;
    rdat      = '0;
    set_hit   = '0;
    trig_hit  = '0;
    for (int k = 0; k < NSTAT; k++) begin
      if (adr == AW'(STAT_BASE + k)) begin
        mapped    = 1'b1;
        read_only = 1'b1;
        rdat      = stat_in[k*DW +: DW];
      end
    end
    for (int k = 0; k < NSET; k++) begin
      if (adr == AW'(SET_BASE + k)) begin
        mapped     = 1'b1;
        set_hit[k] = 1'b1;
        rdat       = set_q[k];
      end
    end
    for (int k = 0; k < NTRIG; k++) begin
      if (adr == AW'(TRIG_BASE + k)) begin
        mapped         = 1'b1;
        trig_hit[k]    = 1'b1;
        rdat           = '0;
        rdat[TRIG_BIT] = trig_out[k];
      end
    end
    acc_err = !mapped || (we && read_only);
    acc_ok  = !acc_err;
  end

  for (genvar g = 0; g < NSET; g++) begin : g_set
    always_ff @(posedge clk) begin
      if (rst)                            set_q[g] <= SET_RST[g*DW +: DW];
      else if (go && we && set_hit[g])    set_q[g] <= wdat;
    end
    assign set_out[g*DW +: DW] = set_q[g];
  end

  for (genvar g = 0; g < NTRIG; g++) begin : g_trig
    always_ff @(posedge clk) begin
      if (rst)                                          trig_out[g] <= 1'b0;
      else if (go && we && trig_hit[g] && wdat[TRIG_BIT]) trig_out[g] <= 1'b1;
      else if (trig_clr[g])                             trig_out[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/regbank_dual_host.sv
module regbank_dual_host
  import rb_pkg::*;
#(
  parameter int NM        = NUM_HOSTS,
  parameter int AW        = ADDR_W,
  parameter int DW        = DATA_W,
  parameter int NSTAT     = NUM_STAT,
  parameter int NSET      = NUM_SET,
  parameter int NTRIG     = NUM_TRIG,
  parameter int SBASE     = STAT_BASE,
  parameter int CBASE     = SET_BASE,
  parameter int TBASE     = TRIG_BASE,
  parameter int TBIT      = TRIG_BIT,
  parameter logic [NSET*DW-1:0] SET_RST = SET_RESET_VALS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NM-1:0]       m_cyc,
  input  logic [NM-1:0]       m_stb,
  input  logic [NM-1:0]       m_we,
  input  logic [NM*AW-1:0]    m_adr,
  input  logic [NM*DW-1:0]    m_wdat,
  output logic [NM-1:0]       s_ack,
  output logic [NM-1:0]       s_err,
  output logic [NM-1:0]       s_rty,
  output logic [NM*DW-1:0]    s_rdat,
  input  logic [NSTAT*DW-1:0] stat_in,
  output logic [NSET*DW-1:0]  set_out,
  output logic [NTRIG-1:0]    trig_out,
  input  logic [NTRIG-1:0]    trig_clr
);
  logic [NM-1:0] gnt;
  logic          sel_stb;
  logic          sel_we;
  logic [AW-1:0] sel_adr;
  logic [DW-1:0] sel_wdat;
  logic          busy;
  logic          go;
  logic          acc_ok;
  logic          acc_err;
  logic [DW-1:0] rdat;

  rb_arbiter #(.NM(NM)) u_arb (
    .clk (clk),
    .rst (rst),
    .cyc (m_cyc),
    .gnt (gnt)
  );

  always_comb begin
    sel_stb  = 1'b0;
    sel_we   = 1'b0;
    sel_adr  = '0;
    sel_wdat = '0;
    for (int i = 0; i < NM; i++) begin
      if (gnt[i]) begin
        sel_stb  = m_stb[i] & m_cyc[i];
        sel_we   = m_we[i];
        sel_adr  = m_adr[i*AW +: AW];
        sel_wdat = m_wdat[i*DW +: DW];
      end
    end
  end

  // one idle edge after each response so a held strobe is not served twice
  assign busy = |(s_ack | s_err);
  assign go   = sel_stb & !busy;

  rb_regs #(
    .AW(AW), .DW(DW), .NSTAT(NSTAT), .NSET(NSET), .NTRIG(NTRIG),
    .STAT_BASE(SBASE), .SET_BASE(CBASE), .TRIG_BASE(TBASE),
    .TRIG_BIT(TBIT), .SET_RST(SET_RST)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .we       (sel_we),
    .adr      (sel_adr),
    .wdat     (sel_wdat),
    .stat_in  (stat_in),
    .trig_clr (trig_clr),
    .acc_ok   (acc_ok),
    .acc_err  (acc_err),
    .rdat     (rdat),
    .set_out  (set_out),
    .trig_out (trig_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ack  <= '0;
      s_err  <= '0;
      s_rdat <= '0;
    end else begin
      for (int i = 0; i < NM; i++) begin
        s_ack[i]            <= go & gnt[i] & acc_ok;
        s_err[i]            <= go & gnt[i] & acc_err;
        s_rdat[i*DW +: DW]  <= (go && gnt[i] && acc_ok && !sel_we) ? rdat : '0;
      end
    end
  end

  assign s_rty = '0;
endmodule

// File: rtl/rb_checker.sv
module rb_checker #(
  parameter int NM    = 2,
  parameter int NTRIG = 3,
  parameter int SETW  = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [NM-1:0]    gnt,
  input logic [NM-1:0]    cyc,
  input logic [NM-1:0]    ack,
  input logic [NM-1:0]    err,
  input logic [SETW-1:0]  set_out,
  input logic [NTRIG-1:0] trig_out,
  input logic [NTRIG-1:0] trig_clr
);
  a_r1_single_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  a_r4_one_responder: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack | err));

  a_r6_set_moves_on_ack: assert property (@(posedge clk) disable iff (rst)
    !$stable(set_out) |-> |ack);

  for (genvar i = 0; i < NM; i++) begin : g_host
    a_r2_grant_sticky: assert property (@(posedge clk) disable iff (rst)
      (gnt[i] && cyc[i]) |=> gnt[i]);
    a_r3_resp_needs_grant: assert property (@(posedge clk) disable iff (rst)
      (ack[i] || err[i]) |-> $past(gnt[i]));
    a_r4_ack_one_cycle: assert property (@(posedge clk) disable iff (rst)
      ack[i] |=> !ack[i]);
    a_r4_ack_err_excl: assert property (@(posedge clk) disable iff (rst)
      !(ack[i] && err[i]));
  end

  for (genvar k = 0; k < NTRIG; k++) begin : g_trig
    a_r7_trig_rise_on_ack: assert property (@(posedge clk) disable iff (rst)
      $rose(trig_out[k]) |-> |ack);
    a_r8_trig_holds: assert property (@(posedge clk) disable iff (rst)
      (trig_out[k] && !trig_clr[k]) |=> trig_out[k]);
  end
endmodule

bind regbank_dual_host rb_checker #(
  .NM(NM), .NTRIG(NTRIG), .SETW(NSET*DW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .gnt      (gnt),
  .cyc      (m_cyc),
  .ack      (s_ack),
  .err      (s_err),
  .set_out  (set_out),
  .trig_out (trig_out),
  .trig_clr (trig_clr)
);

// File: tb/tb_regbank_dual_host.sv
`timescale 1ns/1ps
module tb_regbank_dual_host;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  m_cyc = '0, m_stb = '0, m_we = '0;
  logic [7:0]  m_adr = '0;
  logic [15:0] m_wdat = '0;
  logic [1:0]  s_ack, s_err, s_rty;
  logic [15:0] s_rdat;
  logic [23:0] stat_in;
  logic [23:0] set_out;
  logic [2:0]  trig_out;
  logic [2:0]  trig_clr = '0;

  logic [7:0] mstat [3];
  logic [7:0] mset  [3];
  logic [2:0] mtrig;
  int vectors = 0;
  int fails   = 0;

  assign stat_in = {mstat[2], mstat[1], mstat[0]};

  regbank_dual_host dut (
    .clk(clk), .rst(rst), .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we),
    .m_adr(m_adr), .m_wdat(m_wdat), .s_ack(s_ack), .s_err(s_err),
    .s_rty(s_rty), .s_rdat(s_rdat), .stat_in(stat_in), .set_out(set_out),
    .trig_out(trig_out), .trig_clr(trig_clr)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit exp_err(input bit we, input logic [3:0] a);
    bit mapped;
    mapped = (a <= 4'h2) || (a >= 4'h6 && a <= 4'h8) || (a >= 4'hA && a <= 4'hC);
    return !mapped || (we && a <= 4'h2);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a <= 4'h2)                return mstat[a];
    if (a >= 4'h6 && a <= 4'h8)   return mset[a - 4'h6];
    if (a >= 4'hA && a <= 4'hC)   return {7'b0, mtrig[a - 4'hA]};
    return 8'h00;
  endfunction

  task automatic drive(input int m, input bit we, input logic [3:0] a, input logic [7:0] d);
    m_cyc[m] = 1'b1; m_stb[m] = 1'b1; m_we[m] = we;
    m_adr[m*4 +: 4] = a; m_wdat[m*8 +: 8] = d;
  endtask

  task automatic wait_resp(input int m, output bit ack, output bit err, output logic [7:0] rd);
    bit got = 0;
    ack = 0; err = 0; rd = '0;
    for (int n = 0; n < 40 && !got; n++) begin
      @(negedge clk);
      if (s_ack[m] || s_err[m]) begin
        got = 1; ack = s_ack[m]; err = s_err[m]; rd = s_rdat[m*8 +: 8];
      end
    end
    if (!got) begin
      vectors++; fails++;
      $display("FAIL R4: host %0d no response, actual none expected one", m);
    end
  endtask

  // full access checked against the model; caller is at a negedge
  task automatic access(input int m, input bit we, input logic [3:0] a,
                        input logic [7:0] d, input bit keep);
    bit ack, err, e;
    logic [7:0] rd, er;
    e  = exp_err(we, a);
    er = (we || e) ? 8'h00 : exp_rd(a);
    drive(m, we, a, d);
    wait_resp(m, ack, err, rd);
    m_stb[m] = 1'b0;
    if (!keep) m_cyc[m] = 1'b0;
    chk(e ? "R10/R5 err" : "R4 ack", {30'b0, ack, err}, {30'b0, !e, e});
    chk("R5/R6/R9 read data", {24'b0, rd}, {24'b0, er});
    chk("R4 retry low", {30'b0, s_rty}, 32'h0);
    if (!e && we) begin
      if (a >= 4'h6 && a <= 4'h8) mset[a - 4'h6] = d;
      if (a >= 4'hA && a <= 4'hC && d[0]) mtrig[a - 4'hA] = 1'b1;
    end
    chk("R6 set_out", {8'b0, set_out}, {8'b0, mset[2], mset[1], mset[0]});
    chk("R7 trig_out", {29'b0, trig_out}, {29'b0, mtrig});
  endtask

  task automatic pulse_clr(input logic [2:0] mask);
    trig_clr = mask;
    @(negedge clk);
    trig_clr = '0;
    mtrig = mtrig & ~mask;
    chk("R8 clear", {29'b0, trig_out}, {29'b0, mtrig});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    bit a0, e0, a1, e1;
    logic [7:0] r0, r1;
    void'($urandom(32'd1234));
    mstat[0] = 8'h11; mstat[1] = 8'h22; mstat[2] = 8'h33;
    mset[0] = 8'h05; mset[1] = 8'h3C; mset[2] = 8'hAA;
    mtrig = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 settings", {8'b0, set_out}, 32'h00AA3C05);
    chk("R11 triggers", {29'b0, trig_out}, 32'h0);
    chk("R11 no response", {28'b0, s_ack, s_err}, 32'h0);

    // R5 status reads, write to status errs
    access(0, 0, 4'h1, 8'h00, 0);
    access(1, 1, 4'h2, 8'hFF, 0);
    // R10 unmapped
    access(0, 0, 4'hF, 8'h00, 0);
    access(1, 1, 4'h4, 8'h5A, 0);
    // R6 setting write and readback
    access(1, 1, 4'h7, 8'hC3, 0);
    access(0, 0, 4'h7, 8'h00, 0);

    // R7 write with bit0 clear leaves flag low
    access(0, 1, 4'hA, 8'hFE, 0);
    chk("R7 no set on bit0=0", {31'b0, trig_out[0]}, 32'h0);
    access(0, 1, 4'hA, 8'h01, 0);
    chk("R7 set", {31'b0, trig_out[0]}, 32'h1);
    access(1, 0, 4'hA, 8'h00, 0);  // R9 read returns 0x01
    access(1, 1, 4'hB, 8'h81, 0);
    repeat (5) @(negedge clk);
    chk("R8 holds", {30'b0, trig_out[1:0]}, 32'h3);
    pulse_clr(3'b001);
    chk("R8 cleared only bit0", {29'b0, trig_out}, 32'h2);
    // R8 set wins over same-edge clear
    trig_clr = 3'b100;
    drive(0, 1, 4'hC, 8'h01);
    wait_resp(0, a0, e0, r0);
    m_stb[0] = 0; m_cyc[0] = 0; trig_clr = '0;
    mtrig[2] = 1'b1;
    chk("R8 set wins", {31'b0, trig_out[2]}, 32'h1);
    @(negedge clk);
    chk("R8 set wins held", {31'b0, trig_out[2]}, 32'h1);

    // R1 simultaneous requests: Q first
    drive(0, 0, 4'h6, 8'h00);
    drive(1, 0, 4'h7, 8'h00);
    wait_resp(0, a0, e0, r0);
    chk("R1 Q served", {31'b0, a0}, 32'h1);
    chk("R1 Q data", {24'b0, r0}, {24'b0, mset[0]});
    chk("R3 P silent", {29'b0, s_ack[1], s_err[1], s_rty[1]}, 32'h0);
    chk("R3 P rdat zero", {24'b0, s_rdat[15:8]}, 32'h0);
    m_stb[0] = 0; m_cyc[0] = 0;
    wait_resp(1, a1, e1, r1);
    chk("R1 P served after", {31'b0, a1}, 32'h1);
    chk("R1 P data", {24'b0, r1}, {24'b0, mset[1]});
    m_stb[1] = 0;  // P keeps cyc

    // R2 P owns bus; Q asks, P's next access still first
    @(negedge clk);
    drive(0, 0, 4'h8, 8'h00);
    drive(1, 1, 4'h8, 8'h77);
    wait_resp(1, a1, e1, r1);
    chk("R2 P kept bus", {31'b0, a1}, 32'h1);
    chk("R2 Q waits", {30'b0, s_ack[0], s_err[0]}, 32'h0);
    mset[2] = 8'h77;
    m_stb[1] = 0; m_cyc[1] = 0;
    wait_resp(0, a0, e0, r0);
    m_stb[0] = 0; m_cyc[0] = 0;
    chk("R2 Q after release", {31'b0, a0}, 32'h1);
    chk("R2 Q sees P write", {24'b0, r0}, 32'h77);
    @(negedge clk);

    // random traffic
    for (int it = 0; it < 400; it++) begin
      int m;
      logic [3:0] a;
      m = int'($urandom_range(1, 0));
      a = 4'($urandom);
      mstat[it % 3] = 8'($urandom);
      if ($urandom_range(7, 0) == 0) pulse_clr(3'($urandom));
      access(m, 1'($urandom), a, 8'($urandom), 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule